// File: doc/BRIEF.md
# Pipelined Bit Gather/Scatter Unit

This block moves selected bits of a 32-bit word under control of a 32-bit mask. In gather mode the data bits that sit under the mask's ones are packed together at the bottom of the result. In scatter mode the low bits of the data are spread out over the mask's ones. Both directions are computed in five shift stages of 1, 2, 4, 8 and 16 positions, not one bit at a time. The set of bits moved at each stage is found by counting, with a prefix XOR, the mask zeros that lie below each bit.

The datapath has ten register stages. The first five derive the five per-stage move masks from the mask alone, and these masks then travel with the operand. The last five apply them to the data: in rising order for gather and in falling order for scatter. Operands enter through a valid/ready handshake and results leave through another one. When the consumer is ready, one new operation can start every clock. When the output is held back, the whole pipeline freezes.

Top module: `px_unit`

## Requirements
- R1: With `in_op` = 0 (gather), the data bits at the mask's one positions, taken from lowest to highest, appear in consecutive result bits starting at bit 0, and every higher result bit is 0. For example, data 0b100010 with mask 0b101010 gives 0b101.
- R2: With `in_op` = 1 (scatter), data bits 0, 1, 2, … are placed in order into the mask's one positions from lowest to highest, and result bits where the mask is 0 are 0. For example, data 0b101 with mask 0b101010 gives 0b100010.
- R3: A mask of all zeros gives a result of 0 in both modes.
- R4: An operation accepted at a rising edge, with no stall, leaves through the output handshake at the 10th rising edge after it. Each stalled edge in between adds exactly one edge to this.
- R5: When `out_ready` stays high, `in_ready` stays high, so an operation can be accepted at every edge.
- R6: While `out_valid` is high and `out_ready` is low, the output keeps the same result and stays valid. Every accepted operation comes out exactly once, and in the order it was accepted.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: A synchronous active-high `rst` drops every operation in flight. After reset, `out_valid` is low until a new operation has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand offered |
| in_op | input | 1 | 0 = gather, 1 = scatter |
| in_data | input | 32 | Data word |
| in_mask | input | 32 | Selection mask |
| in_ready | output | 1 | Operand taken at this edge if valid |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_result | output | 32 | Gathered or scattered word |

## Verification
Each result is due ten rising edges after its operand is accepted, plus one edge for every edge at which the output was held. The bench keeps a running count of held edges. When a result leaves, it subtracts that result's accept edge and the held edges in between, and the remainder must be exactly ten. Results are compared, in order of acceptance, against a bit-at-a-time model. All inputs and outputs are handled half a period away from the active edge. In every cycle the bench also checks that a held output stays unchanged and that the ready signal follows the output state.

// File: rtl/px_pkg.sv
package px_pkg;
    localparam int PX_W  = 32;
    localparam int PX_LG = $clog2(PX_W);
    localparam int PX_NST = 2 * PX_LG;

    typedef struct packed {
        logic                      vld;
        logic                      op;
        logic [PX_W-1:0]           x;
        logic [PX_W-1:0]           m0;
        logic [PX_W-1:0]           m;
        logic [PX_W-1:0]           k;
        logic [PX_LG-1:0][PX_W-1:0] mv;
    } px_slot_t;
endpackage

// File: rtl/px_mvgen.sv
// One move-mask stage: picks the mask bits whose count of lower zeros
// has bit STEP set, and compacts the working mask by 2**STEP.
module px_mvgen #(
    parameter int W    = px_pkg::PX_W,
    parameter int STEP = 0
) (
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] k_i,
    output logic [W-1:0] mv_o,
    output logic [W-1:0] m_o,
    output logic [W-1:0] k_o
);
    localparam int SH = 1 << STEP;

    logic [W-1:0] pfx;

    always_comb begin
        pfx = k_i;
        for (int s = 1; s < W; s = s * 2) begin
            pfx = pfx ^ (pfx << s);
        end
        mv_o = pfx & m_i;
        m_o  = (m_i ^ mv_o) | (mv_o >> SH);
        k_o  = k_i & ~pfx;
    end
endmodule

// File: rtl/px_apply.sv
// One data stage: gather uses move mask IDX shifting right by 2**IDX,
// scatter uses move mask LG-1-IDX shifting left.
module px_apply #(
    parameter int W    = px_pkg::PX_W,
    parameter int LG   = px_pkg::PX_LG,
    parameter int IDX  = 0,
    parameter bit LAST = 1'b0
) (
    input  logic                 op_i,
    input  logic [W-1:0]         x_i,
    input  logic [LG-1:0][W-1:0] mv_i,
    input  logic [W-1:0]         m0_i,
    output logic [W-1:0]         x_o
);
    localparam int JD   = LG - 1 - IDX;
    localparam int SH_G = 1 << IDX;
    localparam int SH_S = 1 << JD;

    logic [W-1:0] t, gat, sct;

    always_comb begin
        t   = x_i & mv_i[IDX];
        gat = (x_i ^ t) | (t >> SH_G);
        sct = (x_i & ~mv_i[JD]) | ((x_i << SH_S) & mv_i[JD]);
        if (LAST) begin
            sct = sct & m0_i;
        end
        x_o = op_i ? sct : gat;
    end
endmodule

// File: rtl/px_unit.sv
module px_unit (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_op,
    input  logic [px_pkg::PX_W-1:0] in_data,
    input  logic [px_pkg::PX_W-1:0] in_mask,
    output logic                   in_ready,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [px_pkg::PX_W-1:0] out_result
);
    import px_pkg::*;

    localparam int W   = PX_W;
    localparam int LG  = PX_LG;
    localparam int NST = PX_NST;

    px_slot_t pipe_d [NST];
    px_slot_t pipe_q [NST];
    px_slot_t feed   [NST];
    px_slot_t src_in;

    logic [W-1:0] mg_mv [LG];
    logic [W-1:0] mg_m  [LG];
    logic [W-1:0] mg_k  [LG];
    logic [W-1:0] ap_x  [LG];
    logic         adv;
    logic         fin_op;
    logic [W-1:0] fin_m0;

    always_comb begin
        src_in.vld = in_valid;
        src_in.op  = in_op;
        src_in.x   = in_op ? in_data : (in_data & in_mask);
        src_in.m0  = in_mask;
        src_in.m   = in_mask;
        src_in.k   = (~in_mask) << 1;
        src_in.mv  = '0;
        feed[0] = src_in;
        for (int i = 1; i < NST; i++) begin
            feed[i] = pipe_q[i-1];
        end
    end

    for (genvar g = 0; g < LG; g++) begin : g_mask
        px_mvgen #(.W(W), .STEP(g)) u_mvgen (
            .m_i  (feed[g].m),
            .k_i  (feed[g].k),
            .mv_o (mg_mv[g]),
            .m_o  (mg_m[g]),
            .k_o  (mg_k[g])
        );
    end

    for (genvar a = 0; a < LG; a++) begin : g_data
        px_apply #(.W(W), .LG(LG), .IDX(a), .LAST(a == LG - 1)) u_apply (
            .op_i (feed[LG+a].op),
            .x_i  (feed[LG+a].x),
            .mv_i (feed[LG+a].mv),
            .m0_i (feed[LG+a].m0),
            .x_o  (ap_x[a])
        );
    end

    always_comb begin
        adv = !pipe_q[NST-1].vld || out_ready;
        for (int i = 0; i < LG; i++) begin
            pipe_d[i] = pipe_q[i];
            if (adv) begin
                pipe_d[i]       = feed[i];
                pipe_d[i].mv[i] = mg_mv[i];
                pipe_d[i].m     = mg_m[i];
                pipe_d[i].k     = mg_k[i];
            end
        end
        for (int i = LG; i < NST; i++) begin
            pipe_d[i] = pipe_q[i];
            if (adv) begin
                pipe_d[i]   = feed[i];
                pipe_d[i].x = ap_x[i-LG];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NST; i++) begin
                pipe_q[i].vld <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NST; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign in_ready   = adv;
    assign out_valid  = pipe_q[NST-1].vld;
    assign out_result = pipe_q[NST-1].x;
    assign fin_op     = pipe_q[NST-1].op;
    assign fin_m0     = pipe_q[NST-1].m0;
endmodule

// File: rtl/px_unit_chk.sv
module px_unit_chk #(
    parameter int W = px_pkg::PX_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_result,
    input logic         fin_op,
    input logic [W-1:0] fin_m0
);
    a_r1_gather_packed_low: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !fin_op) |-> ((out_result >> $countones(fin_m0)) == '0));

    a_r2_scatter_inside_mask: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fin_op) |-> ((out_result & ~fin_m0) == '0));

    a_r3_empty_mask_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fin_m0 == '0) |-> (out_result == '0));

    a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

    a_r7_blocked_no_accept: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_reset_empties: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
endmodule

bind px_unit px_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .fin_op     (fin_op),
    .fin_m0     (fin_m0)
);

// File: tb/px_unit_tb.sv
module px_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_op, in_ready;
    logic [31:0] in_data, in_mask;
    logic        out_valid, out_ready;
    logic [31:0] out_result;

    always #10 clk = ~clk;

    px_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .in_mask(in_mask), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
    );

    typedef struct {
        logic [31:0] exp;
        logic        op;
        logic [31:0] m;
        int          e;
        int          s;
    } ent_t;

    ent_t        q[$];
    int          errs = 0, checks = 0, edge_n = 0, stall_n = 0;
    logic        prev_hold = 1'b0;
    logic [31:0] prev_res = '0;
    bit          done = 1'b0;

    function automatic logic [31:0] ref_gather(logic [31:0] d, logic [31:0] m);
        logic [31:0] r = '0;
        int k = 0;
        for (int i = 0; i < 32; i++) if (m[i]) begin r[k] = d[i]; k++; end
        return r;
    endfunction

    function automatic logic [31:0] ref_scatter(logic [31:0] d, logic [31:0] m);
        logic [31:0] r = '0;
        int k = 0;
        for (int i = 0; i < 32; i++) if (m[i]) begin r[i] = d[k]; k++; end
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; the transfers decided here happen
    // at the following rising edge.
    task automatic step(bit iv, bit op, logic [31:0] d, logic [31:0] m, bit rdy);
        ent_t en;
        in_valid = iv; in_op = op; in_data = d; in_mask = m; out_ready = rdy;
        #1;
        if (prev_hold) chk(out_valid && out_result == prev_res, "R6 hold", out_result, prev_res);
        chk(in_ready == (!out_valid || out_ready), "R7/R5 ready", 32'(in_ready), 32'(!out_valid || out_ready));
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "R6 extra result", out_result, 32'h0);
            end else begin
                en = q.pop_front();
                chk(out_result == en.exp,
                    (en.m == 0) ? "R3 zero mask" : (en.op ? "R2 scatter" : "R1 gather"),
                    out_result, en.exp);
                chk(edge_n + 1 - en.e == 10 + stall_n - en.s, "R4 latency",
                    32'(edge_n + 1 - en.e), 32'(10 + stall_n - en.s));
            end
        end
        if (in_valid && in_ready) begin
            en.exp = op ? ref_scatter(d, m) : ref_gather(d, m);
            en.op = op; en.m = m; en.e = edge_n + 1; en.s = stall_n;
            q.push_back(en);
        end
        prev_hold = out_valid && !out_ready;
        prev_res  = out_result;
        if (prev_hold) stall_n++;
        edge_n++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        edge_n += 3;
        rst = 1'b0;
        q.delete();
        prev_hold = 1'b0;
        #1;
        chk(!out_valid, "R8 reset valid", 32'(out_valid), 32'h0);
        @(negedge clk);
        edge_n++;
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && q.size() != 0; i++) step(0, 0, 0, 0, 1);
        chk(q.size() == 0, "R6 no loss", 32'(q.size()), 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] masks[6];
        in_op = 0; in_data = 0; in_mask = 0;
        @(negedge clk);
        do_reset();
        #1;
        chk(in_ready, "R8 ready after reset", 32'(in_ready), 32'h1);

        // Directed vectors (R1, R2, R3)
        step(1, 0, 32'b100010, 32'b101010, 1);
        step(1, 0, 32'b101010, 32'b101010, 1);
        step(1, 1, 32'b101,    32'b101010, 1);
        step(1, 1, 32'b111,    32'b101010, 1);
        step(1, 0, 32'hFFFFFFFF, 32'h0, 1);
        step(1, 1, 32'hFFFFFFFF, 32'h0, 1);
        drain();

        // Special masks, both modes, back to back (R5)
        masks = '{32'hFFFFFFFF, 32'h0, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'hAAAAAAAA, 32'h80000001};
        for (int mi = 0; mi < 6; mi++)
            for (int j = 0; j < 8; j++)
                step(1, j[0], $urandom, masks[mi], 1);
        for (int b = 0; b < 32; b++) begin
            step(1, 0, $urandom, 32'h1 << b, 1);
            step(1, 1, $urandom, 32'h1 << b, 1);
        end
        drain();

        // Random traffic with random backpressure (R4, R6, R7)
        for (int n = 0; n < 3000; n++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom, $urandom,
                 $urandom_range(0, 2) != 0);
        drain();

        // Long stall then release
        for (int n = 0; n < 12; n++) step(1, 1, $urandom, $urandom, 1);
        for (int n = 0; n < 20; n++) step(1, 0, $urandom, $urandom, 0);
        drain();

        // Reset with work in flight (R8)
        for (int n = 0; n < 6; n++) step(1, 0, $urandom, $urandom, 1);
        do_reset();
        for (int n = 0; n < 12; n++) begin
            #1;
            chk(!out_valid, "R8 flushed", 32'(out_valid), 32'h0);
            step(0, 0, 0, 0, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule